// File: doc/BRIEF.md
# RTC Alarm, Wake and Watchdog Controller

This block keeps time in seconds and in milliseconds and matches a programmable 32-bit alarm against the seconds count. The first cycle of a match is one alarm event. What that event does depends on the modelled power state and on two always-on enables. If the chip is powered down and wake is enabled, the event requests power-up and sets a sticky cause bit. If the chip is powered up and the interrupt is enabled, the event sets a sticky interrupt flag. When power returns, the always-on control word is captured into a shadow register. Software reads the cause of the wake-up from that shadow copy.

Time advances on single-cycle tick strobes, 1 Hz for seconds and 1 kHz for milliseconds, so the whole block runs on one clock. A resolution field sets how the millisecond count advances: in steps of 1, 2, 4, 8 or 16. A millisecond watchdog pulses a chip reset once its programmed count runs out, unless software reloads it first. Registers are reached through a plain write strobe and address port. Read data is registered.

Top module: `rtc_wake_ctrl`

## Requirements
- R1: After reset, seconds and millisecond counts are 0, the alarm register holds 0xFFFFFFFF, the control word is 0, and irq, wake_req and wdog_rst are low. Each tick_1hz adds one to the seconds count. A write to address 1 loads the seconds count. Read data for address a appears on reg_rdata one clock after a is presented.
- R2: An alarm event occurs only on the first cycle in which the seconds count (address 1) equals the alarm (address 2). While the two stay equal, no further event occurs. Writing the alarm to the value already counted raises no event.
- R3: An event while pwr_on=1 with the interrupt enable (control bit 1) set drives irq high one clock later and sets status bit 0 (address 4). Writing 1 to status bit 0 clears both. Writing 0 there leaves them set.
- R4: An event while pwr_on=0 never sets irq or the status bit, even with the interrupt enable set.
- R5: An event while pwr_on=0 with the wake enable (control bit 0) set drives wake_req high one clock later and sets the cause bit (control bit 8). wake_req stays high until pwr_on is 1.
- R6: An event while pwr_on=1 leaves the cause bit and wake_req clear. An event while pwr_on=0 with wake disabled also leaves them clear.
- R7: On each rise of pwr_on, the control word is copied to the shadow register (address 5). Later changes to the control word do not show there until the next power-up.
- R8: Control bits 4:2 hold a resolution code e. Codes 0..4 give step s=2^e, and codes 5..7 act as 4. The millisecond count (address 3) adds s on every s-th tick_1khz. A write to the control word or to address 3 restarts the step phase.
- R9: Writing N to address 6 loads the watchdog. After N tick_1khz strobes with no rewrite, wdog_rst is high for exactly one clock. A rewrite reloads the count. N=0 disables the watchdog.
- R10: The cause bit clears only when software writes the control word with bit 8 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, one per second |
| tick_1khz | input | 1 | One-cycle strobe, one per millisecond |
| pwr_on | input | 1 | Modelled power state, 1 = powered up |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Alarm interrupt, sticky |
| wake_req | output | 1 | Power-up request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that the tick strobes are single-cycle pulses. They also assume that pwr_on changes only between clock edges and never in the same cycle as a register write that it could race. The seconds-step property holds only on cycles without a seconds load. The bench drives every input on the falling edge and raises each strobe for one cycle. It moves pwr_on only while the write strobe is idle, so each scenario separates one power state from the next.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;

  localparam int ADDR_W = 3;
  localparam int RES_W  = 3;
  localparam int CTRL_W = 9;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_SEC    = 3'd1,
    A_ALARM  = 3'd2,
    A_MSEC   = 3'd3,
    A_STAT   = 3'd4,
    A_SHADOW = 3'd5,
    A_WDOG   = 3'd6,
    A_NONE   = 3'd7
  } addr_e;

  typedef struct packed {
    logic             alarm_wake;
    logic [RES_W-1:0] res;
    logic             irq_en;
    logic             wake_en;
  } persist_t;

  function automatic logic [CTRL_W-1:0] persist_pack(persist_t p);
    return {p.alarm_wake, 3'b000, p.res, p.irq_en, p.wake_en};
  endfunction

  function automatic persist_t persist_unpack(logic [CTRL_W-1:0] w);
    persist_t p;
    p.wake_en    = w[0];
    p.irq_en     = w[1];
    p.res        = w[4:2];
    p.alarm_wake = w[8];
    return p;
  endfunction

endpackage

// File: rtl/rtc_time_base.sv
module rtc_time_base #(
  parameter int CNT_W   = 32,
  parameter int MAX_RES = 4,
  parameter int RES_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_s,
  input  logic             tick_ms,
  input  logic             sec_ld,
  input  logic             ms_ld,
  input  logic             pre_clr,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [RES_W-1:0] res,
  output logic [CNT_W-1:0] sec,
  output logic [CNT_W-1:0] msec
);
  localparam int PRE_W = (MAX_RES > 0) ? MAX_RES : 1;

  logic [RES_W-1:0] expo;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_last;
  logic [CNT_W-1:0] step;

  assign expo     = (res > RES_W'(MAX_RES)) ? RES_W'(MAX_RES) : res;
  assign pre_last = PRE_W'((32'd1 << expo) - 32'd1);
  assign step     = CNT_W'(1) << expo;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec <= '0;
    end else if (sec_ld) begin
      sec <= ld_val;
    end else if (tick_s) begin
      sec <= sec + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msec  <= '0;
      pre_q <= '0;
    end else if (ms_ld) begin
      msec  <= ld_val;
      pre_q <= '0;
    end else if (pre_clr) begin
      pre_q <= '0;
    end else if (tick_ms) begin
      if (pre_q == pre_last) begin
        pre_q <= '0;
        msec  <= msec + step;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] sec,
  input  logic [CNT_W-1:0] alarm,
  input  logic             pwr_on,
  input  logic             wake_en,
  input  logic             irq_en,
  output logic             wake_set,
  output logic             irq_set,
  output logic             wake_req
);
  logic match;
  logic match_q;
  logic evt;

  assign match    = (sec == alarm);
  assign evt      = match && !match_q;
  assign wake_set = evt && !pwr_on && wake_en;
  assign irq_set  = evt && pwr_on && irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      match_q <= match;
      if (pwr_on) begin
        wake_req <= 1'b0;
      end else if (wake_set) begin
        wake_req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] remain,
  output logic             fire
);
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (ld) begin
        remain <= ld_val;
      end else if (tick_ms && (remain != '0)) begin
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) begin
          fire <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rtc_wake_ctrl.sv
module rtc_wake_ctrl
  import rtc_wake_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MAX_RES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              tick_1khz,
  input  logic              pwr_on,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              wake_req,
  output logic              wdog_rst
);
  addr_e           addr;
  logic            wr_ctrl, wr_sec, wr_alarm, wr_msec, wr_stat, wr_wdog;
  persist_t        persist_q;
  persist_t        shadow_q;
  logic            pwr_q;
  logic            irq_pend;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] sec_cnt;
  logic [CNT_W-1:0] ms_cnt;
  logic [CNT_W-1:0] wd_remain;
  logic            wake_set;
  logic            irq_set;
  logic            sec_ld;
  logic            alarm_cause;

  assign addr     = addr_e'(reg_addr);
  assign wr_ctrl  = reg_wr && (addr == A_CTRL);
  assign wr_sec   = reg_wr && (addr == A_SEC);
  assign wr_alarm = reg_wr && (addr == A_ALARM);
  assign wr_msec  = reg_wr && (addr == A_MSEC);
  assign wr_stat  = reg_wr && (addr == A_STAT);
  assign wr_wdog  = reg_wr && (addr == A_WDOG);
  assign sec_ld   = wr_sec;
  assign alarm_cause = persist_q.alarm_wake;

  rtc_time_base #(
    .CNT_W  (CNT_W),
    .MAX_RES(MAX_RES),
    .RES_W  (RES_W)
  ) u_time (
    .clk    (clk),
    .rst    (rst),
    .tick_s (tick_1hz),
    .tick_ms(tick_1khz),
    .sec_ld (wr_sec),
    .ms_ld  (wr_msec),
    .pre_clr(wr_ctrl),
    .ld_val (reg_wdata),
    .res    (persist_q.res),
    .sec    (sec_cnt),
    .msec   (ms_cnt)
  );

  rtc_alarm_unit #(.CNT_W(CNT_W)) u_alarm (
    .clk     (clk),
    .rst     (rst),
    .sec     (sec_cnt),
    .alarm   (alarm_q),
    .pwr_on  (pwr_on),
    .wake_en (persist_q.wake_en),
    .irq_en  (persist_q.irq_en),
    .wake_set(wake_set),
    .irq_set (irq_set),
    .wake_req(wake_req)
  );

  rtc_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .tick_ms(tick_1khz),
    .ld     (wr_wdog),
    .ld_val (reg_wdata),
    .remain (wd_remain),
    .fire   (wdog_rst)
  );

  // always-on control word; a wake event outranks a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      persist_q <= '0;
    end else begin
      if (wr_ctrl) begin
        persist_q <= persist_unpack(reg_wdata[CTRL_W-1:0]);
      end
      if (wake_set) begin
        persist_q.alarm_wake <= 1'b1;
      end
    end
  end

  // shadow copy captured on the power-up edge
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      pwr_q <= pwr_on;
      if (pwr_on && !pwr_q) begin
        shadow_q <= persist_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
    end else if (irq_set) begin
      irq_pend <= 1'b1;
    end else if (wr_stat && reg_wdata[0]) begin
      irq_pend <= 1'b0;
    end
  end

  assign irq = irq_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '1;
    end else if (wr_alarm) begin
      alarm_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (addr)
        A_CTRL:   reg_rdata <= CNT_W'(persist_pack(persist_q));
        A_SEC:    reg_rdata <= sec_cnt;
        A_ALARM:  reg_rdata <= alarm_q;
        A_MSEC:   reg_rdata <= ms_cnt;
        A_STAT:   reg_rdata <= CNT_W'(irq_pend);
        A_SHADOW: reg_rdata <= CNT_W'(persist_pack(shadow_q));
        A_WDOG:   reg_rdata <= wd_remain;
        default:  reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rtc_wake_ctrl_chk.sv
module rtc_wake_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_on,
  input logic             irq,
  input logic             wake_req,
  input logic             wdog_rst,
  input logic             alarm_cause,
  input logic             tick_1hz,
  input logic             sec_ld,
  input logic [CNT_W-1:0] sec
);
  // R1
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !sec_ld) |=> (sec == $past(sec) + CNT_W'(1)));

  // R4
  irq_powered_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(pwr_on));

  // R5
  wake_down_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_req) |-> !$past(pwr_on));

  // R5
  wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_req && !pwr_on) |=> wake_req);

  // R6
  cause_down_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_cause) |-> !$past(pwr_on));

  // R9
  wdog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> !wdog_rst);

endmodule

bind rtc_wake_ctrl rtc_wake_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_on     (pwr_on),
  .irq        (irq),
  .wake_req   (wake_req),
  .wdog_rst   (wdog_rst),
  .alarm_cause(alarm_cause),
  .tick_1hz   (tick_1hz),
  .sec_ld     (sec_ld),
  .sec        (sec_cnt)
);

// File: tb/rtc_wake_ctrl_bench.sv
module rtc_wake_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        tick_1khz = 1'b0;
  logic        pwr_on = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd7;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, wake_req, wdog_rst;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  rtc_wake_ctrl u_rtc_wake_ctrl (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_1khz(tick_1khz),
    .pwr_on(pwr_on), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .wake_req(wake_req), .wdog_rst(wdog_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd7;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_addr = 3'd7;
  endtask

  task automatic sec_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic ms_tick();
    @(negedge clk); tick_1khz = 1'b1;
    @(negedge clk); tick_1khz = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 wake_req", {31'd0, wake_req}, 0);
    check("R1 wdog_rst", {31'd0, wdog_rst}, 0);
    rd(3'd1, rv); check("R1 sec reset", rv, 0);
    rd(3'd2, rv); check("R1 alarm reset", rv, 32'hFFFF_FFFF);
    rd(3'd0, rv); check("R1 ctrl reset", rv, 0);
    rd(3'd3, rv); check("R1 msec reset", rv, 0);

    // R1 load and step sweep
    wr(3'd1, 32'd100);
    for (int i = 1; i <= 6; i++) begin
      sec_tick();
      rd(3'd1, rv); check("R1 sec step", rv, 32'd100 + i);
    end
    wr(3'd1, 32'hFFFF_FFFF);
    sec_tick();
    rd(3'd1, rv); check("R1 sec wrap", rv, 0);

    // R3 / R2 / R6 powered-up interrupt
    wr(3'd0, 32'h2);
    wr(3'd1, 32'd10);
    wr(3'd2, 32'd12);
    sec_tick(); idle(2);
    check("R2 no early event", {31'd0, irq}, 0);
    sec_tick(); idle(1);
    check("R3 irq set", {31'd0, irq}, 1);
    rd(3'd4, rv); check("R3 status set", rv, 1);
    wr(3'd4, 32'h0);
    rd(3'd4, rv); check("R3 write 0 keeps", rv, 1);
    wr(3'd4, 32'h1); idle(3);
    check("R3 w1c clears irq", {31'd0, irq}, 0);
    check("R2 no refire while equal", {31'd0, irq}, 0);
    rd(3'd4, rv); check("R3 status cleared", rv, 0);
    rd(3'd0, rv); check("R6 no cause when up", rv, 32'h2);
    check("R6 no wake when up", {31'd0, wake_req}, 0);
    wr(3'd2, 32'd12); idle(3);
    check("R2 rewrite equal no event", {31'd0, irq}, 0);
    wr(3'd2, 32'd13);
    sec_tick(); idle(1);
    check("R2 next match fires", {31'd0, irq}, 1);
    wr(3'd4, 32'h1);

    // R4 / R5 powered-down wake
    wr(3'd0, 32'h3);
    wr(3'd1, 32'd50);
    wr(3'd2, 32'd51);
    @(negedge clk); pwr_on = 1'b0;
    sec_tick(); idle(1);
    check("R5 wake_req set", {31'd0, wake_req}, 1);
    check("R4 no irq when down", {31'd0, irq}, 0);
    rd(3'd0, rv); check("R5 cause bit set", rv, 32'h103);
    rd(3'd4, rv); check("R4 status clear", rv, 0);
    idle(4);
    check("R5 wake_req held", {31'd0, wake_req}, 1);
    @(negedge clk); pwr_on = 1'b1;
    @(negedge clk);
    check("R5 wake_req drops", {31'd0, wake_req}, 0);
    check("R4 no irq after up", {31'd0, irq}, 0);
    rd(3'd5, rv); check("R7 shadow holds cause", rv, 32'h103);

    // R10 / R7
    wr(3'd0, 32'h3);
    rd(3'd0, rv); check("R10 cause cleared", rv, 32'h3);
    rd(3'd5, rv); check("R7 shadow unchanged", rv, 32'h103);
    @(negedge clk); pwr_on = 1'b0;
    idle(2);
    @(negedge clk); pwr_on = 1'b1;
    idle(1);
    rd(3'd5, rv); check("R7 shadow recaptured", rv, 32'h3);

    // R6 down with wake disabled
    wr(3'd0, 32'h2);
    wr(3'd1, 32'd70);
    wr(3'd2, 32'd71);
    @(negedge clk); pwr_on = 1'b0;
    sec_tick(); idle(2);
    check("R6 no wake when disabled", {31'd0, wake_req}, 0);
    rd(3'd0, rv); check("R6 cause stays clear", rv, 32'h2);
    @(negedge clk); pwr_on = 1'b1;
    idle(1);

    // R8 resolution sweep
    for (int e = 0; e < 8; e++) begin
      int ee;
      int t;
      ee = (e > 4) ? 4 : e;
      t  = 37;
      wr(3'd0, 32'(e) << 2);
      wr(3'd3, 32'd0);
      for (int k = 1; k <= t; k++) begin
        ms_tick();
        if (k % 8 == 0 || k == t) begin
          rd(3'd3, rv);
          check("R8 msec step", rv, 32'((k >> ee) << ee));
        end
      end
    end

    // R9 watchdog sweep
    wr(3'd0, 32'h0);
    for (int n = 1; n <= 12; n++) begin
      int early;
      early = 0;
      wr(3'd6, 32'(n));
      for (int k = 1; k < n; k++) begin
        ms_tick();
        if (wdog_rst) early++;
      end
      check("R9 no early reset", 32'(early), 0);
      ms_tick();
      check("R9 reset pulse", {31'd0, wdog_rst}, 1);
      @(negedge clk);
      check("R9 single cycle", {31'd0, wdog_rst}, 0);
    end
    wr(3'd6, 32'd5);
    repeat (3) ms_tick();
    wr(3'd6, 32'd5);
    begin
      int early;
      early = 0;
      for (int k = 1; k < 5; k++) begin
        ms_tick();
        if (wdog_rst) early++;
      end
      check("R9 reload postpones", 32'(early), 0);
    end
    ms_tick();
    check("R9 reset after reload", {31'd0, wdog_rst}, 1);
    wr(3'd6, 32'd0);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
        ms_tick();
        if (wdog_rst) seen++;
      end
      check("R9 zero disables", 32'(seen), 0);
    end

    finish_run();
  end

endmodule